// File: doc/BRIEF.md
# Bank-Group Command Timing Guard

This block decides, cycle by cycle, whether a candidate DRAM command may go out to a rank built as bank groups of banks. The candidate arrives as a valid/ready offer: the scheduler sets `cmd_valid` with the command type, bank group and bank. The block raises `cmd_ready` when that command meets every spacing rule that is currently in force. A command is issued on a rising clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is a combinational function of the offered command and the internal timers, so a scheduler may present a different candidate each cycle to find one that is allowed. It does not have to hold a rejected offer. A rejected command leaves no trace.

Each bank has two saturating down-counters: one gates activates and one gates column commands. An issued command reloads counters in every bank. Each counter takes the larger of its remaining time and the new delay, so an earlier, longer constraint is never shortened. The new delay is short for banks in other groups and long for banks in the same group. A small pool of window timers caps activates in any rolling window. With one group (or none) configured, grouping has no effect and only the short spacings apply.

Top module: `bg_timing_guard`

## Requirements
- R1: After reset every timer is clear. An activate or a column command to any bank is ready at once.
- R2: A read or write to a bank whose group matches the last issued column command is not ready until 6 cycles after that command.
- R3: A read or write to a different group is ready 4 cycles after the last issued column command, provided nothing else blocks it.
- R4: An activate to the same group as the last issued activate is not ready until 6 cycles after it.
- R5: An activate to a different group is ready 4 cycles after the last issued activate, provided nothing else blocks it.
- R6: At most 4 activates issue within any 26 consecutive cycles. A fifth activate is ready 26 cycles after the oldest of the four.
- R7: A read or write to a bank is not ready until 17 cycles after that bank's activate.
- R8: A command offered while `cmd_ready` is low changes no timer.
- R9: Reloads take the maximum. A short column spacing issued while a longer activate-to-column wait is pending does not shorten that wait.
- R10: `cmd_type` encodes 0 = no-op, 1 = activate, 2 = read, 3 = write. A no-op is always ready and changes no timer.
- R11: With the group count set to 1, every activate and column spacing is the short value, whatever the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A candidate command is offered |
| cmd_ready | output | 1 | The offered command meets all timing; issue happens when valid and ready are both high |
| cmd_type | input | 2 | 0 no-op, 1 activate, 2 read, 3 write |
| cmd_bg | input | BG_W (2) | Bank group of the candidate |
| cmd_bank | input | BK_W (2) | Bank within the group |

## Verification
Several rules hold on every cycle and are checked by assertions. No two activates and no two column commands issue on back-to-back edges. A column command never follows the activate of its own bank on the next edge. A no-op is always ready. The count of issued activates inside any sliding window never exceeds the limit. The exact spacing values need the bench's scenarios, because each depends on the history of which groups were used. These values are the 4 and 6 cycle spacings, the 17-cycle activate-to-column wait, the 26-cycle release of the window, and the rule that a reload never shortens a pending wait. The same holds for the flat configuration and for the absence of side effects from rejected offers.

// File: rtl/bg_timing_pkg.sv
package bg_timing_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycles a timer must hold so that the next issue lands exactly d cycles later
  function automatic int unsigned hold_of(input int unsigned d);
    return (d > 0) ? d - 1 : 0;
  endfunction

endpackage

// File: rtl/hold_counter.sv
module hold_counter #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          open
);
  logic [CW-1:0] cnt, dec, nxt;

  always_comb begin
    dec = (cnt == '0) ? '0 : cnt - 1'b1;
    nxt = (load && (val > dec)) ? val : dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

  assign open = (cnt == '0);
endmodule

// File: rtl/act_window.sv
module act_window #(
  parameter int LIMIT = 4,
  parameter int WIN   = 26
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic room
);
  localparam int WW = $clog2(WIN + 1);
  localparam logic [WW-1:0] LOAD_V = WW'((WIN > 0) ? WIN - 1 : 0);

  logic [WW-1:0]    slot [LIMIT];
  logic [LIMIT-1:0] free;
  logic [LIMIT-1:0] pick;

  always_comb begin
    logic found;
    found = 1'b0;
    for (int i = 0; i < LIMIT; i++) begin
      free[i] = (slot[i] == '0);
      pick[i] = take && free[i] && !found;
      if (free[i]) found = 1'b1;
    end
  end

  assign room = |free;

  for (genvar g = 0; g < LIMIT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot[g] <= '0;
      else if (pick[g])    slot[g] <= LOAD_V;
      else if (!free[g])   slot[g] <= slot[g] - 1'b1;
    end
  end
endmodule

// File: rtl/bg_timing_guard.sv
module bg_timing_guard
  import bg_timing_pkg::*;
#(
  parameter int NUM_BG       = 4,
  parameter int BANKS_PER_BG = 4,
  parameter int T_CCD_S      = 4,
  parameter int T_CCD_L      = 6,
  parameter int T_RRD_S      = 4,
  parameter int T_RRD_L      = 6,
  parameter int T_RCD        = 17,
  parameter int T_FAW        = 26,
  parameter int ACT_LIMIT    = 4,
  localparam int BG_W = (NUM_BG > 1) ? $clog2(NUM_BG) : 1,
  localparam int BK_W = (BANKS_PER_BG > 1) ? $clog2(BANKS_PER_BG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_type,
  input  logic [BG_W-1:0] cmd_bg,
  input  logic [BK_W-1:0] cmd_bank
);
  localparam bit GRP_ON    = (NUM_BG > 1);
  localparam int NG        = GRP_ON ? NUM_BG : 1;
  localparam int NB        = NG * BANKS_PER_BG;
  localparam int RRD_SAME  = GRP_ON ? max_u(T_RRD_S, T_RRD_L) : T_RRD_S;
  localparam int CCD_SAME  = GRP_ON ? max_u(T_CCD_S, T_CCD_L) : T_CCD_S;
  localparam int MAXD      = max_u(max_u(RRD_SAME, CCD_SAME), T_RCD);
  localparam int CW        = $clog2(MAXD + 1);
  localparam logic [CW-1:0] V_RRD_S = CW'(hold_of(T_RRD_S));
  localparam logic [CW-1:0] V_RRD_G = CW'(hold_of(RRD_SAME));
  localparam logic [CW-1:0] V_CCD_S = CW'(hold_of(T_CCD_S));
  localparam logic [CW-1:0] V_CCD_G = CW'(hold_of(CCD_SAME));
  localparam logic [CW-1:0] V_RCD   = CW'(hold_of(T_RCD));

  cmd_e        ctype;
  logic        is_act, is_col, is_nop;
  int          sel;
  logic        in_range;
  logic [NB-1:0] act_open, col_open;
  logic        faw_room;
  logic        acc_act, acc_col;

  always_comb begin
    ctype    = cmd_e'(cmd_type);
    is_nop   = (ctype == CMD_NOP);
    is_act   = (ctype == CMD_ACT);
    is_col   = (ctype == CMD_RD) || (ctype == CMD_WR);
    sel      = int'(cmd_bank) + (GRP_ON ? int'(cmd_bg) * BANKS_PER_BG : 0);
    in_range = (int'(cmd_bank) < BANKS_PER_BG) && (!GRP_ON || int'(cmd_bg) < NUM_BG);
    cmd_ready = is_nop;
    if (in_range && is_act) cmd_ready = act_open[sel] && faw_room;
    if (in_range && is_col) cmd_ready = col_open[sel];
  end

  assign acc_act = cmd_valid && cmd_ready && is_act;
  assign acc_col = cmd_valid && cmd_ready && is_col;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int GRP = b / BANKS_PER_BG;
    logic          same_grp;
    logic          self_hit;
    logic          col_ld;
    logic [CW-1:0] act_val, col_val;

    always_comb begin
      same_grp = GRP_ON && (int'(cmd_bg) == GRP);
      self_hit = (sel == b);
      act_val  = same_grp ? V_RRD_G : V_RRD_S;
      col_ld   = acc_col || (acc_act && self_hit);
      col_val  = acc_act ? V_RCD : (same_grp ? V_CCD_G : V_CCD_S);
    end

    hold_counter #(.CW(CW)) u_act (
      .clk(clk), .rst_n(rst_n), .load(acc_act), .val(act_val), .open(act_open[b])
    );
    hold_counter #(.CW(CW)) u_col (
      .clk(clk), .rst_n(rst_n), .load(col_ld), .val(col_val), .open(col_open[b])
    );
  end

  act_window #(.LIMIT(ACT_LIMIT), .WIN(T_FAW)) u_faw (
    .clk(clk), .rst_n(rst_n), .take(acc_act), .room(faw_room)
  );
endmodule

// File: rtl/bg_timing_guard_chk.sv
module bg_timing_guard_chk #(
  parameter int BG_W      = 2,
  parameter int BK_W      = 2,
  parameter int T_FAW     = 26,
  parameter int ACT_LIMIT = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [1:0]      cmd_type,
  input logic [BG_W-1:0] cmd_bg,
  input logic [BK_W-1:0] cmd_bank
);
  logic iss_act, iss_col;
  logic [T_FAW-1:0] hist;

  assign iss_act = cmd_valid && cmd_ready && (cmd_type == 2'd1);
  assign iss_col = cmd_valid && cmd_ready && cmd_type[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[T_FAW-2:0], iss_act};
  end

  // assumes short activate spacing of at least 2 cycles
  p_act_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_act |=> !iss_act);

  // assumes short column spacing of at least 2 cycles
  p_col_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_col |=> !iss_col);

  p_act_to_col_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_act |=> !(iss_col && cmd_bg == $past(cmd_bg) && cmd_bank == $past(cmd_bank)));

  p_window_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hist[T_FAW-2:0], iss_act}) <= ACT_LIMIT);

  p_nop_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_type == 2'd0) |-> cmd_ready);
endmodule

bind bg_timing_guard bg_timing_guard_chk #(
  .BG_W(BG_W), .BK_W(BK_W), .T_FAW(T_FAW), .ACT_LIMIT(ACT_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_type(cmd_type), .cmd_bg(cmd_bg), .cmd_bank(cmd_bank)
);

// File: tb/bg_timing_guard_test.sv
module bg_timing_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;
  localparam logic [1:0] NOP = 2'd0, ACT = 2'd1, RD = 2'd2, WR = 2'd3;

  // {idle[7:0], type[1:0], bg[1:0], bank[1:0], expect, req[3:0]}
  localparam logic [18:0] VEC [NV] = '{
    {8'd0,  ACT, 2'd0, 2'd0, 1'b1, 4'd1},  // R1  edge 0
    {8'd2,  ACT, 2'd1, 2'd0, 1'b0, 4'd5},  // R5  edge 3, too early
    {8'd0,  ACT, 2'd1, 2'd0, 1'b1, 4'd8},  // R8  edge 4, prior reject left nothing
    {8'd0,  ACT, 2'd1, 2'd1, 1'b0, 4'd4},  // R4  edge 5
    {8'd3,  ACT, 2'd1, 2'd1, 1'b0, 4'd4},  // R4  edge 9
    {8'd0,  ACT, 2'd1, 2'd1, 1'b1, 4'd4},  // R4  edge 10
    {8'd3,  ACT, 2'd2, 2'd0, 1'b1, 4'd5},  // R5  edge 14
    {8'd3,  ACT, 2'd3, 2'd0, 1'b0, 4'd6},  // R6  edge 18, window full
    {8'd6,  ACT, 2'd3, 2'd0, 1'b0, 4'd6},  // R6  edge 25
    {8'd0,  ACT, 2'd3, 2'd0, 1'b1, 4'd6},  // R6  edge 26
    {8'd15, RD,  2'd3, 2'd0, 1'b0, 4'd7},  // R7  edge 42
    {8'd0,  RD,  2'd3, 2'd0, 1'b1, 4'd7},  // R7  edge 43
    {8'd0,  RD,  2'd3, 2'd1, 1'b0, 4'd2},  // R2  edge 44
    {8'd3,  WR,  2'd3, 2'd1, 1'b0, 4'd2},  // R2  edge 48
    {8'd0,  WR,  2'd3, 2'd1, 1'b1, 4'd2},  // R2  edge 49
    {8'd0,  RD,  2'd2, 2'd0, 1'b0, 4'd3},  // R3  edge 50
    {8'd1,  RD,  2'd2, 2'd0, 1'b0, 4'd3},  // R3  edge 52
    {8'd0,  RD,  2'd2, 2'd0, 1'b1, 4'd3},  // R3  edge 53
    {8'd0,  NOP, 2'd0, 2'd0, 1'b1, 4'd10}, // R10 edge 54
    {8'd0,  RD,  2'd2, 2'd1, 1'b0, 4'd2},  // R2  edge 55
    {8'd3,  RD,  2'd2, 2'd1, 1'b1, 4'd2},  // R2  edge 59
    {8'd0,  ACT, 2'd0, 2'd2, 1'b1, 4'd5},  // R5  edge 60
    {8'd3,  RD,  2'd1, 2'd0, 1'b1, 4'd3},  // R3  edge 64
    {8'd5,  RD,  2'd0, 2'd2, 1'b0, 4'd9},  // R9  edge 70
    {8'd5,  RD,  2'd0, 2'd2, 1'b0, 4'd9},  // R9  edge 76
    {8'd0,  RD,  2'd0, 2'd2, 1'b1, 4'd7}   // R7  edge 77
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_type = 2'd0;
  logic [1:0] cmd_bg = 2'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic rdy, rdy_flat;
  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bg_timing_guard uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy),
    .cmd_type(cmd_type), .cmd_bg(cmd_bg), .cmd_bank(cmd_bank)
  );

  bg_timing_guard #(.NUM_BG(1)) uut_flat (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_flat),
    .cmd_type(cmd_type), .cmd_bg(cmd_bg[0]), .cmd_bank(cmd_bank)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ready=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_type  = NOP;
    end
  endtask

  task automatic offer(input logic [1:0] t, input logic [1:0] g, input logic [1:0] b,
                       input logic exp, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_type = t; cmd_bg = g; cmd_bank = b;
    #1 chk(req, rdy, exp);
  endtask

  task automatic offer2(input logic [1:0] t, input logic [1:0] g, input logic [1:0] b,
                        input logic exp, input logic exp_flat, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_type = t; cmd_bg = g; cmd_bank = b;
    #1;
    chk(req, rdy, exp);
    chk({req, " flat"}, rdy_flat, exp_flat);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cmd_type = ACT;
    #1 chk("R1 reset act", rdy, 1'b1);
    cmd_type = RD;
    #1 chk("R1 reset col", rdy, 1'b1);
    cmd_type = NOP;

    for (int v = 0; v < NV; v++) begin
      idle(int'(VEC[v][18:11]));
      offer(VEC[v][10:9], VEC[v][8:7], VEC[v][6:5], VEC[v][4],
            $sformatf("R%0d vec%0d", VEC[v][3:0], v));
    end
    idle(1);

    // R1: a mid-run reset clears pending spacing
    offer(ACT, 2'd0, 2'd0, 1'b1, "R1 pre-reset act");
    @(negedge clk);
    cmd_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    offer2(ACT, 2'd0, 2'd1, 1'b1, 1'b1, "R1 after reset");
    // R11: flat config uses short spacing for the same group; grouped uses long
    idle(3);
    offer2(ACT, 2'd0, 2'd0, 1'b0, 1'b1, "R11 same-group +4");
    idle(1);
    offer2(ACT, 2'd0, 2'd2, 1'b1, 1'b0, "R11 +6 / flat +2");
    idle(2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule